// File: doc/BRIEF.md
# Transmit Clock Supervisor for an Eight-Lane Line Transmitter

This block sits between the framer side of an eight-lane line transmitter and its line drivers. Each lane gets a positive-rail and a negative-rail data bit together with its own transmit clock. The block latches the rail pair on one edge of that clock. One shared select picks the rising or the falling edge for all lanes. The latched pair is then passed to the lane's line output.

A free-running master clock supervises every transmit clock after a two-stage synchroniser. A lane whose transmit clock stops in the low state has its output released to high impedance. A lane whose transmit clock stops in the high state sends a continuous all-ones signal instead of data. The all-ones signal is a mark in every bit cell, alternating between the two rails and paced by the master clock. The first level change on a stopped clock returns the lane to data.

One global enable input gates the drive of all eight lanes at once. After reset, and for as long as that enable is low, no lane drives.

Top module: `txclk_supervisor`

## Requirements
- R1: While reset is applied, and afterwards for as long as `tx_oe` is low, every `line_drive` bit is 0 and every `line_pos`/`line_neg` bit is 0.
- R2: `tx_oe` low forces all eight `line_drive`, `line_pos` and `line_neg` bits to 0 in the same cycle, whatever the state of each lane. With `tx_oe` high again, a lane in data mode drives (`line_drive` = 1) in that same cycle.
- R3: A lane whose `tclk` stays low for 16 consecutive synchronised master-clock samples goes to high impedance: `line_drive` = 0 and both rails are 0.
- R4: A lane whose `tclk` stays high for 16 consecutive synchronised samples sends all-ones. `line_drive` is 1, `line_pos` and `line_neg` are complementary, and `line_pos` inverts on every master-clock cycle.
- R5: The stuck state reaches the lane outputs on the 19th rising `mclk` edge after the last transition of the lane's `tclk` input. This count is 2 synchroniser stages, 16 counted samples and 1 output register. Until then the data output of the lane is unchanged.
- R6: With `clk_fall_sel` = 0 the rail pair is latched on the rising edge of `tclk`; with `clk_fall_sel` = 1, on the falling edge. `line_pos` carries the latched `tpos` and `line_neg` the latched `tneg`. The pair appears at the output 4 `mclk` edges after the `tclk` transition reaches the input, and it holds until the next selected edge.
- R7: A stuck lane leaves the stuck state on the first level change of its `tclk`. It then drives data latched on later selected edges.
- R8: Lanes are independent: a stopped clock on one lane does not change the drive or the data of the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_oe | input | 1 | Global drive enable for all lanes |
| clk_fall_sel | input | 1 | 0: latch rails on rising `tclk` edge, 1: on falling edge |
| tclk | input | 8 | Per-lane transmit clock, asynchronous to `mclk` |
| tpos | input | 8 | Per-lane positive-rail data |
| tneg | input | 8 | Per-lane negative-rail data |
| line_pos | output | 8 | Per-lane positive-rail output |
| line_neg | output | 8 | Per-lane negative-rail output |
| line_drive | output | 8 | Per-lane drive enable, 0 means high impedance |

## Verification
Data capture is tried with the rail pair changed in the middle of both clock phases, using a different value in each phase. The latched value therefore shows which edge took it, in rising and in falling mode. Clocks are stopped low on one lane and high on another while the others keep running. This separates high impedance from all-ones and checks that the lanes are independent. A single-lane transition is timed one cycle before and one cycle after the 19-edge point, which catches a counter that is one too short or one too long. The global enable is dropped and raised while data flows, and every lane is then run again to show recovery.

// File: rtl/txsup_pkg.sv
package txsup_pkg;

    typedef enum logic [1:0] {
        LINE_HIZ  = 2'd0,
        LINE_DATA = 2'd1,
        LINE_ONES = 2'd2
    } line_mode_e;

    typedef struct packed {
        logic drive;
        logic pos;
        logic neg;
    } line_out_t;

endpackage

// File: rtl/txsup_sync.sv
module txsup_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stg[STAGES-1];

endmodule

// File: rtl/txsup_stuck_det.sv
module txsup_stuck_det #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic change_o,
    output logic level_o,
    output logic stuck_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        change_o = (lvl_i != st_q.lvl);
        st_d.lvl = lvl_i;
        if (change_o) begin
            st_d.cnt = CNT_W'(1);
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stuck_o = (st_q.cnt == CNT_MAX);
    assign level_o = st_q.lvl;

    // R5: run-length counter saturates and never passes the limit
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R7: a level change while stuck ends the stuck state one cycle later
    assert_stuck_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_o && change_o) |=> !stuck_o);

endmodule

// File: rtl/txsup_chan.sv
module txsup_chan
    import txsup_pkg::*;
#(
    parameter int STUCK_LIMIT = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tclk_i,
    input  logic      pos_i,
    input  logic      neg_i,
    input  logic      fall_sel_i,
    output line_out_t out_o
);

    localparam int SMP_W = 3;

    typedef struct packed {
        logic      cap_pos;
        logic      cap_neg;
        logic      phase;
        line_out_t out;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic [SMP_W-1:0] smp;
    logic             lvl_s;
    logic             change;
    logic             level;
    logic             stuck;
    logic             edge_hit;
    line_mode_e       mode;

    txsup_sync #(
        .WIDTH (SMP_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({tclk_i, pos_i, neg_i}),
        .sync_o (smp)
    );

    assign lvl_s = smp[2];

    txsup_stuck_det #(
        .LIMIT(STUCK_LIMIT)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_s),
        .change_o(change),
        .level_o (level),
        .stuck_o (stuck)
    );

    // selected edge: rising when fall_sel_i=0, falling when fall_sel_i=1
    assign edge_hit = change && (lvl_s != fall_sel_i);

    always_comb begin
        if (!stuck) begin
            mode = LINE_DATA;
        end else if (level) begin
            mode = LINE_ONES;
        end else begin
            mode = LINE_HIZ;
        end
    end

    always_comb begin
        st_d = st_q;
        if (edge_hit) begin
            st_d.cap_pos = smp[1];
            st_d.cap_neg = smp[0];
        end
        st_d.phase = (mode == LINE_ONES) ? ~st_q.phase : 1'b0;
        case (mode)
            LINE_ONES: begin
                st_d.out.drive = 1'b1;
                st_d.out.pos   = st_q.phase;
                st_d.out.neg   = ~st_q.phase;
            end
            LINE_DATA: begin
                st_d.out.drive = 1'b1;
                st_d.out.pos   = st_q.cap_pos;
                st_d.out.neg   = st_q.cap_neg;
            end
            default: begin
                st_d.out = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    // R3: clock stuck low releases the lane
    assert_stuck_low_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck && !level) |=> (!out_o.drive && !out_o.pos && !out_o.neg));

    // R4: clock stuck high drives complementary rails
    assert_stuck_high_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck && level) |=> (out_o.drive && (out_o.pos != out_o.neg)));

    // R4: the all-ones marks alternate between rails every cycle
    assert_ones_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck && level) ##1 (stuck && level) |=> (out_o.pos != $past(out_o.pos)));

endmodule

// File: rtl/txclk_supervisor.sv
module txclk_supervisor
    import txsup_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int STUCK_LIMIT = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              tx_oe,
    input  logic              clk_fall_sel,
    input  logic [NUM_CH-1:0] tclk,
    input  logic [NUM_CH-1:0] tpos,
    input  logic [NUM_CH-1:0] tneg,
    output logic [NUM_CH-1:0] line_pos,
    output logic [NUM_CH-1:0] line_neg,
    output logic [NUM_CH-1:0] line_drive
);

    logic      fall_sel_s;
    line_out_t chan_out [NUM_CH];

    txsup_sync #(
        .WIDTH (1),
        .STAGES(SYNC_STAGES)
    ) u_sel_sync (
        .clk    (mclk),
        .rst_n  (rst_n),
        .async_i(clk_fall_sel),
        .sync_o (fall_sel_s)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        txsup_chan #(
            .STUCK_LIMIT(STUCK_LIMIT),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_chan (
            .clk       (mclk),
            .rst_n     (rst_n),
            .tclk_i    (tclk[ch]),
            .pos_i     (tpos[ch]),
            .neg_i     (tneg[ch]),
            .fall_sel_i(fall_sel_s),
            .out_o     (chan_out[ch])
        );

        // global enable overrides every lane combinationally
        assign line_drive[ch] = tx_oe & chan_out[ch].drive;
        assign line_pos[ch]   = tx_oe & chan_out[ch].pos;
        assign line_neg[ch]   = tx_oe & chan_out[ch].neg;

        // R3: a lane that does not drive leaves both rails at zero
        assert_hiz_rails_R3: assert property (@(posedge mclk) disable iff (!rst_n)
            !line_drive[ch] |-> (!line_pos[ch] && !line_neg[ch]));
    end

endmodule

// File: tb/sim_txclk_supervisor.sv
module sim_txclk_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int WDOG       = 100000;

    logic           mclk = 1'b0;
    logic           rst_n;
    logic           tx_oe;
    logic           clk_fall_sel;
    logic [NCH-1:0] tclk;
    logic [NCH-1:0] tpos;
    logic [NCH-1:0] tneg;
    logic [NCH-1:0] line_pos;
    logic [NCH-1:0] line_neg;
    logic [NCH-1:0] line_drive;

    int n_checks = 0;
    int n_err    = 0;
    int seq      = 0;

    logic [NCH-1:0] run_mask;
    logic [NCH-1:0] stop_lvl;
    logic [1:0]     a_cur  [NCH];
    logic [1:0]     a_prev [NCH];
    logic [1:0]     b_cur  [NCH];
    logic [1:0]     b_prev [NCH];

    txclk_supervisor #(
        .NUM_CH(NCH)
    ) u0 (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .tx_oe       (tx_oe),
        .clk_fall_sel(clk_fall_sel),
        .tclk        (tclk),
        .tpos        (tpos),
        .tneg        (tneg),
        .line_pos    (line_pos),
        .line_neg    (line_neg),
        .line_drive  (line_drive)
    );

    always #(CLK_PERIOD/2) mclk = ~mclk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all_off(input string req);
        for (int ch = 0; ch < NCH; ch++) begin
            check(line_drive[ch] == 1'b0 && line_pos[ch] == 1'b0 && line_neg[ch] == 1'b0,
                  req, $sformatf("lane %0d drive,pos,neg", ch),
                  int'({line_drive[ch], line_pos[ch], line_neg[ch]}), 0);
        end
    endtask

    task automatic check_rails(input bit use_a);
        for (int ch = 0; ch < NCH; ch++) begin
            if (run_mask[ch]) begin
                logic [1:0] exp_v;
                exp_v = use_a ? a_prev[ch] : b_prev[ch];
                check(line_drive[ch] == 1'b1 && {line_pos[ch], line_neg[ch]} == exp_v,
                      use_a ? "R6 fall" : "R6 rise", $sformatf("lane %0d drive,pos,neg", ch),
                      int'({line_drive[ch], line_pos[ch], line_neg[ch]}), int'({1'b1, exp_v}));
            end
        end
    endtask

    // one transmit-clock period is 8 master cycles: rise at phase 0, fall at phase 4,
    // data changes mid-high (phase 2, value A) and mid-low (phase 6, value B = ~A)
    task automatic drive_periods(input int n, input bit chk);
        for (int p = 0; p < n; p++) begin
            for (int ph = 0; ph < 8; ph++) begin
                @(negedge mclk);
                if (ph == 0) begin
                    for (int ch = 0; ch < NCH; ch++) tclk[ch] = run_mask[ch] ? 1'b1 : stop_lvl[ch];
                end
                if (ph == 4) begin
                    for (int ch = 0; ch < NCH; ch++) tclk[ch] = run_mask[ch] ? 1'b0 : stop_lvl[ch];
                end
                if (ph == 2) begin
                    for (int ch = 0; ch < NCH; ch++) begin
                        a_prev[ch] = a_cur[ch];
                        a_cur[ch]  = 2'((seq * 3 + ch * 5 + 1) % 4);
                        tpos[ch]   = a_cur[ch][1];
                        tneg[ch]   = a_cur[ch][0];
                    end
                end
                if (ph == 6) begin
                    for (int ch = 0; ch < NCH; ch++) begin
                        b_prev[ch] = b_cur[ch];
                        b_cur[ch]  = ~a_cur[ch];
                        tpos[ch]   = b_cur[ch][1];
                        tneg[ch]   = b_cur[ch][0];
                    end
                end
                if (chk && p >= 1 && clk_fall_sel && ph == 3) check_rails(1'b1);
                if (chk && p >= 1 && !clk_fall_sel && ph == 7) check_rails(1'b0);
            end
            seq++;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        tx_oe = 1'b0;
        repeat (4) @(negedge mclk);
        check_all_off("R1 in reset");
        @(negedge mclk);
        rst_n = 1'b1;
        drive_periods(3, 1'b0);
        check_all_off("R1 enable low after reset");
    endtask

    task automatic t_rise_data;
        tx_oe = 1'b1;
        clk_fall_sel = 1'b0;
        drive_periods(5, 1'b1);
    endtask

    task automatic t_fall_data;
        clk_fall_sel = 1'b1;
        drive_periods(5, 1'b1);
        clk_fall_sel = 1'b0;
        drive_periods(3, 1'b1);
    endtask

    task automatic t_oe_gate;
        drive_periods(1, 1'b1);
        @(negedge mclk);
        tx_oe = 1'b0;
        #1;
        check_all_off("R2 enable dropped");
        repeat (3) @(negedge mclk);
        check_all_off("R2 enable held low");
        tx_oe = 1'b1;
        #1;
        for (int ch = 0; ch < NCH; ch++)
            check(line_drive[ch] == 1'b1, "R2", $sformatf("lane %0d drive after re-enable", ch),
                  int'(line_drive[ch]), 1);
        drive_periods(2, 1'b1);
    endtask

    task automatic t_stuck_low;
        run_mask[2] = 1'b0;
        stop_lvl[2] = 1'b0;
        drive_periods(5, 1'b1);
        check(line_drive[2] == 1'b0 && line_pos[2] == 1'b0 && line_neg[2] == 1'b0, "R3",
              "lane 2 drive,pos,neg", int'({line_drive[2], line_pos[2], line_neg[2]}), 0);
        check(line_drive[3] == 1'b1, "R8", "lane 3 drive beside stopped lane",
              int'(line_drive[3]), 1);
    endtask

    task automatic t_stuck_high;
        logic p0;
        run_mask[5] = 1'b0;
        stop_lvl[5] = 1'b1;
        drive_periods(5, 1'b1);
        p0 = line_pos[5];
        check(line_drive[5] == 1'b1 && line_pos[5] != line_neg[5], "R4",
              "lane 5 drive and rail difference", int'({line_drive[5], line_pos[5], line_neg[5]}), 5);
        @(negedge mclk);
        check(line_pos[5] == ~p0 && line_neg[5] == p0, "R4", "lane 5 alternation",
              int'({line_pos[5], line_neg[5]}), int'({~p0, p0}));
        check(line_drive[2] == 1'b0 && line_drive[4] == 1'b1, "R8", "lanes 2 and 4 drive",
              int'({line_drive[2], line_drive[4]}), 1);
    endtask

    task automatic t_recover;
        run_mask = '1;
        drive_periods(3, 1'b1);
        for (int ch = 0; ch < NCH; ch++)
            check(line_drive[ch] == 1'b1, "R7", $sformatf("lane %0d drive after restart", ch),
                  int'(line_drive[ch]), 1);
    endtask

    // all clocks rest low after a period; lane 1 then gets one last transition
    task automatic t_threshold;
        logic pp [21];
        logic dd [21];
        @(negedge mclk);
        tclk[1] = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge mclk);
            pp[k] = line_pos[1];
            dd[k] = line_drive[1];
        end
        check(dd[17] == 1'b1 && pp[17] == pp[16], "R5", "lane 1 still data after 17 edges",
              int'({dd[17], pp[17]}), int'({1'b1, pp[16]}));
        check(dd[18] == 1'b1 && pp[18] == pp[17], "R5", "lane 1 still data after 18 edges",
              int'({dd[18], pp[18]}), int'({1'b1, pp[17]}));
        check(dd[19] == 1'b1 && pp[19] == 1'b0, "R5", "lane 1 first all-ones cell after 19 edges",
              int'({dd[19], pp[19]}), 2);
        check(dd[20] == 1'b1 && pp[20] != pp[19], "R5", "lane 1 alternating after 20 edges",
              int'(pp[20]), int'(~pp[19]));
        check(line_drive[0] == 1'b0, "R3", "lane 0 resting low", int'(line_drive[0]), 0);
    endtask

    initial begin
        rst_n        = 1'b0;
        tx_oe        = 1'b0;
        clk_fall_sel = 1'b0;
        tclk         = '0;
        tpos         = '0;
        tneg         = '0;
        run_mask     = '1;
        stop_lvl     = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            a_cur[ch] = '0; a_prev[ch] = '0; b_cur[ch] = '0; b_prev[ch] = '0;
        end
        t_reset();
        t_rise_data();
        t_fall_data();
        t_oe_gate();
        t_stuck_low();
        t_stuck_high();
        t_recover();
        t_threshold();
        t_recover();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge mclk);
        n_err++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule